// File: doc/BRIEF.md
# Paging Control Register and Translation Flush Controller

This block holds the three paging control words of a processor core: the mode word, the translation root word and the extension word. It also holds a gate that masks physical address bit 20. Software writes arrive as one-cycle strobes, one per register, that share a common data bus. The block compares each new value with the value it replaces and decides whether the translation cache outside the block must be invalidated. A change to a paging-relevant field of the mode or extension word asks for a full invalidation. A write to the root word asks for an invalidation of non-global entries, but only while paging is on.

The gate input is sampled every cycle. When it changes, the block rebuilds the 32-bit physical address mask, asks for a full invalidation and asks the execution engine to leave the code it is running. The block also keeps registered copies of mode-derived flags for the rest of the core: a protection-enable copy, a flag that forces segment base addition whenever protection is off, and three floating-point control copies. All request outputs are single-cycle pulses. They appear in the cycle after the strobe or gate change that caused them.

Top module: `pgctl_flush_unit`

## Requirements
- R1: After reset the mode word reads 0x60000010, the root and extension words read 0, the address mask reads 0xFFFFFFFF, no pulse output is high, hid_prot_o is 0, hid_segadd_o is 1 and hid_fpu_o is 0.
- R2: A mode write raises flush_all_o for one cycle, in the cycle after the strobe, only when bit 31 (paging enable), bit 16 (write protect) or bit 0 (protection enable) of the new value differs from the stored value.
- R3: On every mode write, hid_prot_o takes new bit 0, hid_segadd_o takes the inverse of new bit 0, and hid_fpu_o[2:0] takes new bits 3:1. All three are visible in the cycle after the strobe.
- R4: A root write always stores the data word. It raises flush_local_o in the next cycle only if bit 31 of the stored mode word is 1 at the time of the strobe.
- R5: An extension write raises flush_all_o in the next cycle only when bit 4, bit 5 or bit 7 of the new value differs from the stored value.
- R6: When gate_i differs from bit 20 of the current mask, the mask becomes 0xFFEFFFFF with bit 20 set to gate_i. In the next cycle flush_all_o and exit_req_o are both high for one cycle.
- R7: While gate_i equals bit 20 of the mask, the mask holds and exit_req_o stays low.
- R8: Writes in consecutive cycles are each compared with the value left by the previous write. A root write in the cycle right after a mode write sees the new paging bit. A pulse output is low in any cycle whose previous cycle had no cause for it.
- R9: Changes to bits outside the watched groups (for example mode bits 1 to 4, or extension bit 9) update the stored word but raise no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_mode_i | input | 1 | Write strobe for the mode word |
| wr_root_i | input | 1 | Write strobe for the translation root word |
| wr_ext_i | input | 1 | Write strobe for the extension word |
| wr_data_i | input | 32 | Data for any of the three writes |
| gate_i | input | 1 | Requested state of address bit 20 |
| mode_o | output | 32 | Stored mode word |
| root_o | output | 32 | Stored translation root word |
| ext_o | output | 32 | Stored extension word |
| addr_mask_o | output | 32 | Mask applied to physical addresses |
| flush_all_o | output | 1 | Pulse: invalidate all translations |
| flush_local_o | output | 1 | Pulse: invalidate non-global translations |
| exit_req_o | output | 1 | Pulse: ask execution to leave current code |
| hid_prot_o | output | 1 | Copy of protection enable |
| hid_segadd_o | output | 1 | Forced segment base addition flag |
| hid_fpu_o | output | 3 | Floating-point control copies (bits 3:1 of mode) |

## Verification
The assertions check several relations on every cycle. A full flush always traces back to a mode write, an extension write or a gate toggle. A local flush needs a root write made while paging was on. The mask keeps its one-hole shape and changes only together with an exit pulse. The hidden flags stay consistent with the stored mode word. The assertions cannot show whether a given write should have flushed, because that depends on which watched bits actually changed. The scoreboard covers this with a model: changed and unchanged watched bits, unwatched bit changes, back-to-back writes that depend on the previous value, a gate toggle combined with a root write, and a long pseudo-random stream.

// File: rtl/pgctl_pkg.sv
package pgctl_pkg;
   localparam int FPU_FLAG_W = 3;

   typedef struct packed {
      logic                  prot;
      logic                  segadd;
      logic [FPU_FLAG_W-1:0] fpu;
   } pgctl_hidden_t;
endpackage

// File: rtl/pgctl_watch_reg.sv
module pgctl_watch_reg #(
   parameter int              DATA_W       = 32,
   parameter logic [DATA_W-1:0] RESET_VAL  = '0,
   parameter logic [DATA_W-1:0] WATCH_MASK = '0,
   parameter bit              QUALIFY_ONLY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic              qual_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] q_o,
   output logic              hit_o
);
   logic [DATA_W-1:0] q_r;
   logic              hit_r;
   logic              hit_nxt;

   generate
      if (QUALIFY_ONLY) begin : g_qual
         assign hit_nxt = we_i && qual_i;
      end else begin : g_diff
         assign hit_nxt = we_i && qual_i && (|((data_i ^ q_r) & WATCH_MASK));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r   <= RESET_VAL;
         hit_r <= 1'b0;
      end else begin
         hit_r <= hit_nxt;
         if (we_i) q_r <= data_i;
      end
   end

   assign q_o   = q_r;
   assign hit_o = hit_r;
endmodule

// File: rtl/pgctl_gate.sv
module pgctl_gate #(
   parameter int DATA_W   = 32,
   parameter int GATE_BIT = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_i,
   output logic [DATA_W-1:0] mask_o,
   output logic              toggle_o
);
   localparam logic [DATA_W-1:0] GATE_ONE = {{(DATA_W-1){1'b0}}, 1'b1} << GATE_BIT;

   logic [DATA_W-1:0] mask_r;
   logic              toggle_r;
   logic              differs;

   assign differs = (gate_i != mask_r[GATE_BIT]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_r   <= '1;
         toggle_r <= 1'b0;
      end else begin
         toggle_r <= differs;
         if (differs) mask_r <= ~GATE_ONE | (gate_i ? GATE_ONE : '0);
      end
   end

   assign mask_o   = mask_r;
   assign toggle_o = toggle_r;
endmodule

// File: rtl/pgctl_flush_unit.sv
module pgctl_flush_unit #(
   parameter int                DATA_W     = 32,
   parameter logic [DATA_W-1:0] MODE_RESET = 32'h6000_0010,
   parameter int                PE_BIT     = 0,
   parameter int                FPU_LSB    = 1,
   parameter int                WP_BIT     = 16,
   parameter int                PG_BIT     = 31,
   parameter int                PSE_BIT    = 4,
   parameter int                PAE_BIT    = 5,
   parameter int                PGE_BIT    = 7,
   parameter int                GATE_BIT   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mode_i,
   input  logic              wr_root_i,
   input  logic              wr_ext_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              gate_i,
   output logic [DATA_W-1:0] mode_o,
   output logic [DATA_W-1:0] root_o,
   output logic [DATA_W-1:0] ext_o,
   output logic [DATA_W-1:0] addr_mask_o,
   output logic              flush_all_o,
   output logic              flush_local_o,
   output logic              exit_req_o,
   output logic              hid_prot_o,
   output logic              hid_segadd_o,
   output logic [2:0]        hid_fpu_o
);
   import pgctl_pkg::*;

   localparam logic [DATA_W-1:0] ONE        = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] MODE_WATCH = (ONE << PG_BIT) | (ONE << WP_BIT) | (ONE << PE_BIT);
   localparam logic [DATA_W-1:0] EXT_WATCH  = (ONE << PGE_BIT) | (ONE << PAE_BIT) | (ONE << PSE_BIT);

   generate
      if (PG_BIT >= DATA_W || WP_BIT >= DATA_W || PE_BIT >= DATA_W) begin : g_bad_mode
         $error("mode bit position outside data width");
      end
      if (GATE_BIT >= DATA_W) begin : g_bad_gate
         $error("gate bit outside data width");
      end
      if (FPU_LSB + FPU_FLAG_W > DATA_W) begin : g_bad_fpu
         $error("fpu copy field outside data width");
      end
      if (PGE_BIT >= DATA_W || PAE_BIT >= DATA_W || PSE_BIT >= DATA_W) begin : g_bad_ext
         $error("extension bit position outside data width");
      end
   endgenerate

   logic mode_hit, ext_hit, root_hit, gate_toggle;

   pgctl_watch_reg #(
      .DATA_W(DATA_W), .RESET_VAL(MODE_RESET), .WATCH_MASK(MODE_WATCH), .QUALIFY_ONLY(1'b0)
   ) u_mode (
      .clk(clk), .rst_n(rst_n), .we_i(wr_mode_i), .qual_i(1'b1),
      .data_i(wr_data_i), .q_o(mode_o), .hit_o(mode_hit)
   );

   pgctl_watch_reg #(
      .DATA_W(DATA_W), .RESET_VAL('0), .WATCH_MASK('0), .QUALIFY_ONLY(1'b1)
   ) u_root (
      .clk(clk), .rst_n(rst_n), .we_i(wr_root_i), .qual_i(mode_o[PG_BIT]),
      .data_i(wr_data_i), .q_o(root_o), .hit_o(root_hit)
   );

   pgctl_watch_reg #(
      .DATA_W(DATA_W), .RESET_VAL('0), .WATCH_MASK(EXT_WATCH), .QUALIFY_ONLY(1'b0)
   ) u_ext (
      .clk(clk), .rst_n(rst_n), .we_i(wr_ext_i), .qual_i(1'b1),
      .data_i(wr_data_i), .q_o(ext_o), .hit_o(ext_hit)
   );

   pgctl_gate #(.DATA_W(DATA_W), .GATE_BIT(GATE_BIT)) u_gate (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_i),
      .mask_o(addr_mask_o), .toggle_o(gate_toggle)
   );

   // hidden flags: own flops, loaded from the write data on every mode write
   pgctl_hidden_t hid_q;
   pgctl_hidden_t hid_reset;
   pgctl_hidden_t hid_nxt;

   always_comb begin
      hid_reset.prot   = MODE_RESET[PE_BIT];
      hid_reset.segadd = ~MODE_RESET[PE_BIT];
      hid_nxt.prot     = wr_data_i[PE_BIT];
      hid_nxt.segadd   = ~wr_data_i[PE_BIT];
   end

   generate
      for (genvar i = 0; i < FPU_FLAG_W; i++) begin : g_fpu
         assign hid_reset.fpu[i] = MODE_RESET[FPU_LSB + i];
         assign hid_nxt.fpu[i]   = wr_data_i[FPU_LSB + i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)         hid_q <= hid_reset;
      else if (wr_mode_i) hid_q <= hid_nxt;
   end

   assign hid_prot_o    = hid_q.prot;
   assign hid_segadd_o  = hid_q.segadd;
   assign hid_fpu_o     = hid_q.fpu;

   assign flush_all_o   = mode_hit | ext_hit | gate_toggle;
   assign flush_local_o = root_hit;
   assign exit_req_o    = gate_toggle;
endmodule

// File: rtl/pgctl_flush_unit_chk.sv
module pgctl_flush_unit_chk #(
   parameter int DATA_W   = 32,
   parameter int PE_BIT   = 0,
   parameter int FPU_LSB  = 1,
   parameter int PG_BIT   = 31,
   parameter int GATE_BIT = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_mode_i,
   input logic              wr_root_i,
   input logic              wr_ext_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [DATA_W-1:0] mode_o,
   input logic [DATA_W-1:0] root_o,
   input logic [DATA_W-1:0] addr_mask_o,
   input logic              flush_all_o,
   input logic              flush_local_o,
   input logic              exit_req_o,
   input logic              hid_prot_o,
   input logic              hid_segadd_o,
   input logic [2:0]        hid_fpu_o
);
   localparam logic [DATA_W-1:0] GATE_ONE = {{(DATA_W-1){1'b0}}, 1'b1} << GATE_BIT;

   AST_FULL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all_o |-> ($past(wr_mode_i) || $past(wr_ext_i) || exit_req_o)); // R2
   AST_LOCAL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_local_o |-> ($past(wr_root_i) && $past(mode_o[PG_BIT]))); // R4
   AST_ROOT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_root_i |=> (root_o == $past(wr_data_i))); // R4
   AST_EXIT_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
      exit_req_o |-> flush_all_o); // R6
   AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_mask_o | GATE_ONE) == {DATA_W{1'b1}}); // R6
   AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !exit_req_o |-> $stable(addr_mask_o)); // R7
   AST_HIDDEN_PROT: assert property (@(posedge clk) disable iff (!rst_n)
      (hid_prot_o == mode_o[PE_BIT]) && (hid_segadd_o != hid_prot_o)); // R3
   AST_HIDDEN_FPU: assert property (@(posedge clk) disable iff (!rst_n)
      hid_fpu_o == mode_o[FPU_LSB +: 3]); // R3
   AST_LOCAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_root_i |=> !flush_local_o); // R8
endmodule

bind pgctl_flush_unit pgctl_flush_unit_chk #(
   .DATA_W(DATA_W), .PE_BIT(PE_BIT), .FPU_LSB(FPU_LSB), .PG_BIT(PG_BIT), .GATE_BIT(GATE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_mode_i(wr_mode_i), .wr_root_i(wr_root_i),
   .wr_ext_i(wr_ext_i), .wr_data_i(wr_data_i), .mode_o(mode_o), .root_o(root_o),
   .addr_mask_o(addr_mask_o), .flush_all_o(flush_all_o), .flush_local_o(flush_local_o),
   .exit_req_o(exit_req_o), .hid_prot_o(hid_prot_o), .hid_segadd_o(hid_segadd_o),
   .hid_fpu_o(hid_fpu_o)
);

// File: tb/pgctl_flush_unit_tb.sv
`timescale 1ns/1ps
module pgctl_flush_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_mode_i = 1'b0, wr_root_i = 1'b0, wr_ext_i = 1'b0;
   logic [31:0] wr_data_i = '0;
   logic        gate_i = 1'b1;
   logic [31:0] mode_o, root_o, ext_o, addr_mask_o;
   logic        flush_all_o, flush_local_o, exit_req_o;
   logic        hid_prot_o, hid_segadd_o;
   logic [2:0]  hid_fpu_o;

   always #4 clk = ~clk;

   pgctl_flush_unit u_dut (
      .clk(clk), .rst_n(rst_n), .wr_mode_i(wr_mode_i), .wr_root_i(wr_root_i),
      .wr_ext_i(wr_ext_i), .wr_data_i(wr_data_i), .gate_i(gate_i),
      .mode_o(mode_o), .root_o(root_o), .ext_o(ext_o), .addr_mask_o(addr_mask_o),
      .flush_all_o(flush_all_o), .flush_local_o(flush_local_o), .exit_req_o(exit_req_o),
      .hid_prot_o(hid_prot_o), .hid_segadd_o(hid_segadd_o), .hid_fpu_o(hid_fpu_o)
   );

   typedef struct {
      logic        fa, fl, ex, prot, seg;
      logic [2:0]  fpu;
      logic [31:0] mask, mode, root, ext;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          total = 0, bad = 0;
   bit          done = 1'b0;
   logic [31:0] m_mode = 32'h6000_0010, m_root = '0, m_ext = '0, m_mask = 32'hFFFF_FFFF;
   localparam logic [31:0] MODE_WATCH = 32'h8001_0001;
   localparam logic [31:0] EXT_WATCH  = 32'h0000_00B0;

   task automatic compare(input exp_t e);
      total++;
      if ({flush_all_o, flush_local_o, exit_req_o} !== {e.fa, e.fl, e.ex} ||
          addr_mask_o !== e.mask || mode_o !== e.mode || root_o !== e.root ||
          ext_o !== e.ext || hid_prot_o !== e.prot || hid_segadd_o !== e.seg ||
          hid_fpu_o !== e.fpu) begin
         bad++;
         $display("FAIL %s: got fa=%b fl=%b ex=%b mask=%h mode=%h root=%h ext=%h hid=%b%b%b exp fa=%b fl=%b ex=%b mask=%h mode=%h root=%h ext=%h hid=%b%b%b",
            e.tag, flush_all_o, flush_local_o, exit_req_o, addr_mask_o, mode_o, root_o, ext_o,
            hid_prot_o, hid_segadd_o, hid_fpu_o, e.fa, e.fl, e.ex, e.mask, e.mode, e.root,
            e.ext, e.prot, e.seg, e.fpu);
      end
   endtask

   // driver: one call per clock cycle, pushes the outcome expected after the next edge
   task automatic step(input logic wm, input logic wr, input logic we,
                       input logic [31:0] d, input logic g, input string tag);
      exp_t e;
      logic toggle;
      @(negedge clk);
      wr_mode_i = wm; wr_root_i = wr; wr_ext_i = we; wr_data_i = d; gate_i = g;
      toggle = (g != m_mask[20]);
      e.fa = (wm && (((d ^ m_mode) & MODE_WATCH) != 0)) ||
             (we && (((d ^ m_ext) & EXT_WATCH) != 0)) || toggle;
      e.fl = wr && m_mode[31];
      e.ex = toggle;
      if (toggle) m_mask = g ? 32'hFFFF_FFFF : 32'hFFEF_FFFF;
      if (wm) m_mode = d;
      if (wr) m_root = d;
      if (we) m_ext = d;
      e.mask = m_mask; e.mode = m_mode; e.root = m_root; e.ext = m_ext;
      e.prot = m_mode[0]; e.seg = ~m_mode[0]; e.fpu = m_mode[3:1];
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 1'b0, 1'b0, 32'h0, gate_i, tag);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // monitor: sample shortly after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) compare(sb.pop_front());
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog R8: got hang exp completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      exp_t r;
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      r.fa = 0; r.fl = 0; r.ex = 0; r.mask = 32'hFFFF_FFFF; r.mode = 32'h6000_0010;
      r.root = 0; r.ext = 0; r.prot = 0; r.seg = 1; r.fpu = 0; r.tag = "R1";
      compare(r);
      @(negedge clk) rst_n = 1'b1;

      idle("R7");                                      // gate held, nothing happens
      step(1, 0, 0, 32'h6000_0011, 1, "R2");           // protection bit set: flush
      step(1, 0, 0, 32'h6000_001F, 1, "R3");           // fpu copies, no watched change
      step(1, 0, 0, 32'h6000_000F, 1, "R9");           // unwatched bit 4 change
      step(0, 1, 0, 32'h0000_1000, 1, "R4");           // paging off: no local flush
      step(1, 0, 0, 32'h8000_0011, 1, "R2");           // paging on: flush
      step(0, 1, 0, 32'h0000_2000, 1, "R4");           // local flush
      step(1, 0, 0, 32'h8001_0011, 1, "R8");           // write protect change
      step(1, 0, 0, 32'h8001_0011, 1, "R8");           // same value again: no flush
      step(1, 0, 0, 32'h0001_0011, 1, "R8");           // paging off
      step(0, 1, 0, 32'h0000_3000, 1, "R8");           // sees new paging bit: no flush
      step(0, 0, 1, 32'h0000_0010, 1, "R5");           // size ext change
      step(0, 0, 1, 32'h0000_0210, 1, "R9");           // unwatched bit 9
      step(0, 0, 1, 32'h0000_0290, 1, "R5");           // global ext
      step(0, 0, 1, 32'h0000_02B0, 1, "R5");           // address-extension bit
      idle("R8");                                      // pulses drop
      step(0, 0, 0, 32'h0, 0, "R6");                   // gate low
      step(0, 0, 0, 32'h0, 0, "R7");                   // held low
      step(1, 0, 0, 32'h8001_0011, 0, "R2");           // paging on again
      step(0, 1, 0, 32'h0000_4000, 1, "R6");           // toggle together with root write
      idle("R8");

      lf = 32'hACE1_1234;
      for (int i = 0; i < 60; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         step(lf[3] & lf[5], lf[7] & lf[2], lf[11] & lf[13],
              {lf[31], 14'h0, lf[16], 11'h0, lf[4:0]} ^ {24'h0, lf[12] & lf[7], 1'b0, lf[6:5], 4'h0},
              (lf[19:17] == 3'b000) ? ~gate_i : gate_i, "R8");
      end
      idle("R8");
      idle("R7");
      repeat (2) @(posedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule